// File: doc/BRIEF.md
# Ping-pong frame buffer host controller

This block sits between an ISA-style host bus and two 128K×8 static frame-buffer banks. At any moment one bank is filled by the video capture logic and the other is read by the host, so the host can read and the camera can write at the same time. Host software picks which bank plays which role. It does this by writing a bit to an I/O port.

The host addresses the frames through a 64K memory window. A second bit written to the same port gives the top SRAM address bit, so the host reaches all 128K of a field in two pages. The block decodes the port and the window. It generates an active-low read strobe and an active-low write strobe for each bank, and it switches each bank's address lines between the capture scan address and the host address. It presents the capture data to both banks and returns the data of the host-read bank to the host. Every bank-side output and the host read data are registered on the system clock.

Top module: `pingpong_host_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, bank_sel and page are 0 and bank_sel_n is 1. Every read strobe and write strobe (`b0_oe_n`, `b0_we_n`, `b1_oe_n`, `b1_we_n`) is high (inactive), and both bank addresses are 0.
- R2: A port write is accepted only when all of the following hold: host_addr[9:4] equals 6'b100010 (ports 220h to 22Fh), host_aen is 0 and host_iow_n is 0. When host_iow_n later returns high, data bit 0 becomes bank_sel and data bit 1 becomes page. bank_sel_n is the complement of bank_sel. Both are visible on the first clock edge that samples host_iow_n high.
- R3: A port write has no effect on bank_sel or page in two cases: host_aen is 1 (DMA), or host_addr[9:4] differs from 6'b100010.
- R4: A bank read strobe goes low only when host_addr[19:16] equals 4'b1101 (window D0000h to DFFFFh) and host_memr_n is 0. It appears one clock after these inputs are sampled.
- R5: With bank_sel 0, host reads drive b0_oe_n and capture writes (cap_we high) drive b1_we_n. With bank_sel 1, host reads drive b1_oe_n and capture writes drive b0_we_n. Each strobe appears one clock after its request.
- R6: The bank being read takes the address {page, host_addr[15:0]}. The bank being captured takes cap_addr. Both are registered, one clock after their inputs.
- R7: The captured bank never has its read strobe low, and the read bank never has its write strobe low. This holds on every cycle, including the cycle in which bank_sel changes.
- R8: host_rdata is, one clock later, the read data of the bank that bank_sel selects for host reads. Both banks' write data show cap_data one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 20 | Host address bus |
| host_aen | input | 1 | Host DMA address enable, high during DMA |
| host_iow_n | input | 1 | Host I/O write strobe, active low |
| host_memr_n | input | 1 | Host memory read strobe, active low |
| host_wdata | input | 8 | Host data bus, written to the port |
| host_rdata | output | 8 | Frame data returned to the host |
| cap_addr | input | 17 | Capture scan address |
| cap_we | input | 1 | Capture write request, high in the active picture |
| cap_data | input | 8 | Digitised sample from the converter |
| bank_sel | output | 1 | Latched bank-select bit |
| bank_sel_n | output | 1 | Complement of bank_sel |
| page | output | 1 | Latched host page bit (top SRAM address bit) |
| b0_addr | output | 17 | Bank 0 address |
| b0_oe_n | output | 1 | Bank 0 read strobe, active low |
| b0_we_n | output | 1 | Bank 0 write strobe, active low |
| b0_wdata | output | 8 | Bank 0 write data |
| b0_rdata | input | 8 | Bank 0 read data |
| b1_addr | output | 17 | Bank 1 address |
| b1_oe_n | output | 1 | Bank 1 read strobe, active low |
| b1_we_n | output | 1 | Bank 1 write strobe, active low |
| b1_wdata | output | 8 | Bank 1 write data |
| b1_rdata | input | 8 | Bank 1 read data |

## Verification
The bench builds the block with its default parameters: a 20-bit host address, a 17-bit bank address, 8-bit data, port match 100010 at bit 4, and window match 1101. With these values both pages of a 128K field can be reached through the 64K window, and an address one bit away from either match can be tested as a miss. The bench holds a host read and a capture write active across both directions of a bank swap. This tests strobe exclusivity in the very cycle in which the roles change.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    ROLE_HOST_READ = 1'b0,
    ROLE_CAPTURE   = 1'b1
  } bank_role_e;

  function automatic bank_role_e role_of(input logic sel, input int unsigned bank_id);
    logic is_read;
    is_read = (sel == bank_id[0]);
    return is_read ? ROLE_HOST_READ : ROLE_CAPTURE;
  endfunction
endpackage

// File: rtl/pp_port_decode.sv
module pp_port_decode #(
  parameter int unsigned HOST_AW    = 20,
  parameter int unsigned PORT_LSB   = 4,
  parameter int unsigned PORT_W     = 6,
  parameter logic [PORT_W-1:0] PORT_MATCH = 6'b100010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_aen,
  input  logic               host_iow_n,
  input  logic [1:0]         host_bits,
  output logic               sel_next,
  output logic               page_next
);
  localparam int unsigned PORT_MSB = PORT_LSB + PORT_W - 1;

  logic port_sel_n;
  logic latch_clk;
  logic latch_clk_q;
  logic latch_rise;
  logic [1:0] stage_q;
  logic sel_q;
  logic page_q;

  assign port_sel_n = !((host_addr[PORT_MSB:PORT_LSB] == PORT_MATCH) && !host_aen);
  assign latch_clk  = port_sel_n | host_iow_n;
  assign latch_rise = latch_clk && !latch_clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_clk_q <= 1'b1;
      stage_q     <= 2'b00;
      sel_q       <= 1'b0;
      page_q      <= 1'b0;
    end else begin
      latch_clk_q <= latch_clk;
      if (!latch_clk) begin
        stage_q <= host_bits;
      end
      sel_q  <= sel_next;
      page_q <= page_next;
    end
  end

  always_comb begin
    sel_next  = sel_q;
    page_next = page_q;
    if (latch_rise) begin
      sel_next  = stage_q[0];
      page_next = stage_q[1];
    end
  end
endmodule

// File: rtl/pp_win_decode.sv
module pp_win_decode #(
  parameter int unsigned HOST_AW = 20,
  parameter int unsigned WIN_W   = 4,
  parameter logic [WIN_W-1:0] WIN_MATCH = 4'b1101
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_memr_n,
  output logic               host_rd
);
  logic win_sel_n;
  assign win_sel_n = !(host_addr[HOST_AW-1 -: WIN_W] == WIN_MATCH);
  assign host_rd   = !win_sel_n && !host_memr_n;
endmodule

// File: rtl/pp_bank_port.sv
module pp_bank_port
  import pp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_next,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_full_addr,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              cap_we,
  input  logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] addr,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] wdata
);
  bank_role_e role;
  assign role = role_of(sel_next, BANK_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      wdata <= '0;
    end else begin
      wdata <= cap_data;
      if (role == ROLE_HOST_READ) begin
        addr <= host_full_addr;
        oe_n <= !host_rd;
        we_n <= 1'b1;
      end else begin
        addr <= cap_addr;
        oe_n <= 1'b1;
        we_n <= !cap_we;
      end
    end
  end
endmodule

// File: rtl/pingpong_host_ctrl.sv
module pingpong_host_ctrl #(
  parameter int unsigned HOST_AW = 20,
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PORT_LSB = 4,
  parameter int unsigned PORT_W   = 6,
  parameter logic [PORT_W-1:0] PORT_MATCH = 6'b100010,
  parameter int unsigned WIN_W    = 4,
  parameter logic [WIN_W-1:0] WIN_MATCH = 4'b1101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_aen,
  input  logic               host_iow_n,
  input  logic               host_memr_n,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [ADDR_W-1:0]  cap_addr,
  input  logic               cap_we,
  input  logic [DATA_W-1:0]  cap_data,
  output logic               bank_sel,
  output logic               bank_sel_n,
  output logic               page,
  output logic [ADDR_W-1:0]  b0_addr,
  output logic               b0_oe_n,
  output logic               b0_we_n,
  output logic [DATA_W-1:0]  b0_wdata,
  input  logic [DATA_W-1:0]  b0_rdata,
  output logic [ADDR_W-1:0]  b1_addr,
  output logic               b1_oe_n,
  output logic               b1_we_n,
  output logic [DATA_W-1:0]  b1_wdata,
  input  logic [DATA_W-1:0]  b1_rdata
);
  localparam int unsigned OFF_W  = ADDR_W - 1;
  localparam int unsigned NBANKS = 2;

  logic sel_next;
  logic page_next;
  logic host_rd;
  logic [ADDR_W-1:0] host_full_addr;

  logic [ADDR_W-1:0] bk_addr  [NBANKS];
  logic              bk_oe_n  [NBANKS];
  logic              bk_we_n  [NBANKS];
  logic [DATA_W-1:0] bk_wdata [NBANKS];

  pp_port_decode #(
    .HOST_AW(HOST_AW), .PORT_LSB(PORT_LSB), .PORT_W(PORT_W), .PORT_MATCH(PORT_MATCH)
  ) port_dec_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_aen(host_aen),
    .host_iow_n(host_iow_n), .host_bits(host_wdata[1:0]),
    .sel_next(sel_next), .page_next(page_next)
  );

  pp_win_decode #(
    .HOST_AW(HOST_AW), .WIN_W(WIN_W), .WIN_MATCH(WIN_MATCH)
  ) win_dec_i (
    .host_addr(host_addr), .host_memr_n(host_memr_n), .host_rd(host_rd)
  );

  assign host_full_addr = {page_next, host_addr[OFF_W-1:0]};

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    pp_bank_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_ID(g)
    ) port_i (
      .clk(clk), .rst(rst), .sel_next(sel_next), .host_rd(host_rd),
      .host_full_addr(host_full_addr), .cap_addr(cap_addr), .cap_we(cap_we),
      .cap_data(cap_data), .addr(bk_addr[g]), .oe_n(bk_oe_n[g]),
      .we_n(bk_we_n[g]), .wdata(bk_wdata[g])
    );
  end

  assign b0_addr  = bk_addr[0];
  assign b0_oe_n  = bk_oe_n[0];
  assign b0_we_n  = bk_we_n[0];
  assign b0_wdata = bk_wdata[0];
  assign b1_addr  = bk_addr[1];
  assign b1_oe_n  = bk_oe_n[1];
  assign b1_we_n  = bk_we_n[1];
  assign b1_wdata = bk_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel   <= 1'b0;
      bank_sel_n <= 1'b1;
      page       <= 1'b0;
      host_rdata <= '0;
    end else begin
      bank_sel   <= sel_next;
      bank_sel_n <= !sel_next;
      page       <= page_next;
      host_rdata <= sel_next ? b1_rdata : b0_rdata;
    end
  end
endmodule

// File: rtl/pingpong_host_ctrl_chk.sv
module pingpong_host_ctrl_chk #(
  parameter int unsigned HOST_AW = 20,
  parameter int unsigned ADDR_W  = 17
) (
  input logic               clk,
  input logic               rst,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_aen,
  input logic               host_iow_n,
  input logic               host_memr_n,
  input logic [ADDR_W-1:0]  cap_addr,
  input logic               bank_sel,
  input logic               bank_sel_n,
  input logic               page,
  input logic [ADDR_W-1:0]  b1_addr,
  input logic               b0_oe_n,
  input logic               b0_we_n,
  input logic               b1_oe_n,
  input logic               b1_we_n
);
  logic io_wr_low;
  logic win_rd;
  assign io_wr_low = !host_iow_n && !host_aen && (host_addr[9:4] == 6'b100010);
  assign win_rd    = !host_memr_n && (host_addr[HOST_AW-1 -: 4] == 4'b1101);

  p_sel_compl_r2: assert property (@(posedge clk) disable iff (rst)
    bank_sel_n == !bank_sel);

  p_sel_needs_port_write_r3: assert property (@(posedge clk) disable iff (rst)
    (bank_sel != $past(bank_sel) || page != $past(page)) |-> $past(io_wr_low, 2));

  p_read_needs_window_r4: assert property (@(posedge clk) disable iff (rst)
    (!b0_oe_n || !b1_oe_n) |-> $past(win_rd));

  p_route_b0_read_r5: assert property (@(posedge clk) disable iff (rst)
    !b0_oe_n |-> !bank_sel);

  p_route_b1_write_r5: assert property (@(posedge clk) disable iff (rst)
    !b1_we_n |-> !bank_sel);

  p_cap_addr_r6: assert property (@(posedge clk) disable iff (rst)
    !b1_we_n |-> b1_addr == $past(cap_addr));

  p_bank0_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!b0_oe_n && !b0_we_n));

  p_bank1_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!b1_oe_n && !b1_we_n));

  p_one_reader_r7: assert property (@(posedge clk) disable iff (rst)
    !(!b0_oe_n && !b1_oe_n));
endmodule

bind pingpong_host_ctrl pingpong_host_ctrl_chk #(
  .HOST_AW(HOST_AW), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_aen(host_aen),
  .host_iow_n(host_iow_n), .host_memr_n(host_memr_n), .cap_addr(cap_addr),
  .bank_sel(bank_sel), .bank_sel_n(bank_sel_n), .page(page), .b1_addr(b1_addr),
  .b0_oe_n(b0_oe_n), .b0_we_n(b0_we_n), .b1_oe_n(b1_oe_n), .b1_we_n(b1_we_n)
);

// File: tb/pingpong_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module pingpong_host_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] host_addr = '0;
  logic host_aen = 1'b0, host_iow_n = 1'b1, host_memr_n = 1'b1;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [16:0] cap_addr = '0;
  logic cap_we = 1'b0;
  logic [7:0] cap_data = '0;
  logic bank_sel, bank_sel_n, page;
  logic [16:0] b0_addr, b1_addr;
  logic b0_oe_n, b0_we_n, b1_oe_n, b1_we_n;
  logic [7:0] b0_wdata, b1_wdata;
  logic [7:0] b0_rdata = 8'h3C, b1_rdata = 8'hC3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pingpong_host_ctrl dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_aen(host_aen),
    .host_iow_n(host_iow_n), .host_memr_n(host_memr_n), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cap_addr(cap_addr), .cap_we(cap_we), .cap_data(cap_data),
    .bank_sel(bank_sel), .bank_sel_n(bank_sel_n), .page(page),
    .b0_addr(b0_addr), .b0_oe_n(b0_oe_n), .b0_we_n(b0_we_n), .b0_wdata(b0_wdata),
    .b0_rdata(b0_rdata), .b1_addr(b1_addr), .b1_oe_n(b1_oe_n), .b1_we_n(b1_we_n),
    .b1_wdata(b1_wdata), .b1_rdata(b1_rdata)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic port_write(input logic [19:0] a, input logic aen, input logic [7:0] d);
    host_addr = a; host_aen = aen; host_wdata = d; host_iow_n = 1'b0;
    step();
    host_iow_n = 1'b1;
    step();
    host_aen = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "bank_sel", bank_sel, 0);
    check("R1", "bank_sel_n", bank_sel_n, 1);
    check("R1", "page", page, 0);
    check("R1", "strobes", {b0_oe_n, b0_we_n, b1_oe_n, b1_we_n}, 4'hF);
    check("R1", "addrs", {b0_addr, b1_addr}, 0);
    rst = 1'b0;
    step();
    check("R1", "strobes after release", {b0_oe_n, b0_we_n, b1_oe_n, b1_we_n}, 4'hF);
  endtask

  task automatic t_port_accept();
    port_write(20'h00225, 1'b0, 8'h03);
    check("R2", "bank_sel after write 3", bank_sel, 1);
    check("R2", "bank_sel_n after write 3", bank_sel_n, 0);
    check("R2", "page after write 3", page, 1);
    port_write(20'h0022F, 1'b0, 8'h00);
    check("R2", "bank_sel after write 0", bank_sel, 0);
    check("R2", "page after write 0", page, 0);
  endtask

  task automatic t_port_ignored();
    port_write(20'h00220, 1'b1, 8'h03);
    check("R3", "bank_sel with aen high", bank_sel, 0);
    check("R3", "page with aen high", page, 0);
    port_write(20'h00230, 1'b0, 8'h03);
    check("R3", "bank_sel with port 230h", bank_sel, 0);
    port_write(20'h00320, 1'b0, 8'h03);
    check("R3", "page with port 320h", page, 0);
  endtask

  task automatic t_host_read();
    host_addr = 20'hD1234; host_memr_n = 1'b0;
    step();
    check("R4", "b0 read strobe in window", b0_oe_n, 0);
    check("R5", "b1 read strobe sel0", b1_oe_n, 1);
    check("R6", "b0 addr page0", b0_addr, 17'h01234);
    check("R8", "host_rdata from bank0", host_rdata, 8'h3C);
    host_addr = 20'hC1234;
    step();
    check("R4", "read strobes outside window", {b0_oe_n, b1_oe_n}, 2'b11);
    host_addr = 20'hD1234; host_memr_n = 1'b1;
    step();
    check("R4", "no read without memr", {b0_oe_n, b1_oe_n}, 2'b11);
  endtask

  task automatic t_capture();
    cap_addr = 17'h1ABCD; cap_we = 1'b1; cap_data = 8'h5A;
    step();
    check("R5", "b1 write strobe sel0", b1_we_n, 0);
    check("R5", "b0 write strobe sel0", b0_we_n, 1);
    check("R6", "b1 addr = cap_addr", b1_addr, 17'h1ABCD);
    check("R8", "b1 wdata", b1_wdata, 8'h5A);
    cap_we = 1'b0;
    step();
    check("R5", "write strobe released", {b0_we_n, b1_we_n}, 2'b11);
  endtask

  task automatic t_swapped();
    port_write(20'h00221, 1'b0, 8'h03);
    host_addr = 20'hDFFFF; host_memr_n = 1'b0;
    cap_addr = 17'h00042; cap_we = 1'b1; cap_data = 8'hA5;
    step();
    check("R5", "b1 read strobe sel1", b1_oe_n, 0);
    check("R5", "b0 write strobe sel1", b0_we_n, 0);
    check("R5", "idle strobes sel1", {b0_oe_n, b1_we_n}, 2'b11);
    check("R6", "b1 addr page1", b1_addr, 17'h1FFFF);
    check("R6", "b0 addr = cap_addr", b0_addr, 17'h00042);
    check("R8", "host_rdata from bank1", host_rdata, 8'hC3);
    check("R8", "b0 wdata", b0_wdata, 8'hA5);
    host_memr_n = 1'b1; cap_we = 1'b0;
    step();
  endtask

  task automatic excl_sample(input string tag);
    check("R7", {tag, " bank0 not both"}, (!b0_oe_n && !b0_we_n), 0);
    check("R7", {tag, " bank1 not both"}, (!b1_oe_n && !b1_we_n), 0);
    check("R7", {tag, " one reader"}, (!b0_oe_n && !b1_oe_n), 0);
    check("R7", {tag, " one writer"}, (!b0_we_n && !b1_we_n), 0);
  endtask

  task automatic t_swap_exclusive();
    host_memr_n = 1'b0; cap_we = 1'b1;
    for (int k = 0; k < 2; k++) begin
      host_addr = 20'h00220; host_aen = 1'b0; host_wdata = (k == 0) ? 8'h00 : 8'h01;
      host_iow_n = 1'b0;
      step();
      excl_sample("during write");
      host_iow_n = 1'b1;
      step();
      excl_sample("swap edge");
      check("R7", "bank_sel after swap", bank_sel, (k == 0) ? 0 : 1);
      host_addr = 20'hD0000;
      step();
      excl_sample("after swap");
      check("R7", "reader follows sel", (k == 0) ? b0_oe_n : b1_oe_n, 0);
      check("R7", "writer follows sel", (k == 0) ? b1_we_n : b0_we_n, 0);
    end
    host_memr_n = 1'b1; cap_we = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_port_accept();
    t_port_ignored();
    t_host_read();
    t_capture();
    t_swapped();
    t_swap_exclusive();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule